// File: doc/BRIEF.md
# DLL Phase-Shift Setting Controller

This block is the digital half of a delay-locked loop used for strobe capture. On every reference clock edge it moves a period code, which counts delay taps, one step up or down. The direction comes from a phase-detector input. After enough edges the code settles at the number of taps that spans one clock period. The analog delay line sits outside this block; a testbench stands in for it.

The period code is turned into a phase-shift setting. The frequency mode fixes how many delay elements make up one period: 12, 16, 12 or 10. It also fixes the angle of one phase step, which is 360 degrees divided by that count. A phase-select index picks 0 to 4 steps. The setting is the code times the number of steps, divided by the element count and truncated. It is limited to 6 bits in the lowest mode and to 5 bits in the other modes.

Two reset sources, one from logic and one from a pin, are ORed together. Any reset reloads the code and starts a calibration window of 256 cycles. The locked flag stays low for the whole window. Once it rises, it stays high until the next reset. The frequency range of each mode is kept only as a package constant.

Top module: `dll_phase_ctrl`

## Requirements
- R1: When `rst_logic` or `rst_pin` is high at a rising edge, `period_code` becomes 64 and `locked` becomes 0 after that edge.
- R2: `locked` rises after the 256th consecutive rising edge at which neither reset is high, and not earlier.
- R3: Once `locked` is 1, it stays 1 until a reset is sampled, whatever `pd_up`, `freq_mode` and `phase_sel` do.
- R4: At each edge without reset, `period_code` rises by one when `pd_up`=1 and falls by one when `pd_up`=0, both before and after lock.
- R5: `period_code` saturates: it stays at 255 when asked to rise and at 0 when asked to fall.
- R6: The `freq_mode` encoding gives 12 elements per period for 0, 16 for 1, 12 for 2 and 10 for 3. `phase_set` = floor(`period_code` * step / elements).
- R7: A `phase_sel` value above 4 acts as step 4, and `phase_sel`=0 gives `phase_set`=0.
- R8: In mode 0 `phase_set` saturates at 63. In modes 1 to 3 it saturates at 31, so bit 5 is always 0.
- R9: `phase_set` follows `period_code`, `freq_mode` and `phase_sel` within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_logic | input | 1 | Reset from internal logic, sampled synchronously |
| rst_pin | input | 1 | Reset from an external pin, sampled synchronously |
| freq_mode | input | 2 | Frequency mode select, 0 to 3 |
| phase_sel | input | 3 | Requested number of phase steps |
| pd_up | input | 1 | Phase detector: 1 = lengthen code, 0 = shorten code |
| period_code | output | 8 | Measured period in delay taps |
| phase_set | output | 6 | Phase-shift setting for the delay chain |
| locked | output | 1 | Calibration window has elapsed |

## Verification
Some behaviours are checked by the bound assertions on every cycle:
- the reload after reset;
- the one-tap movement of the code and its saturation;
- a lock flag that never drops;
- the lock timing, measured against a counter kept separately in the checker;
- bit 5 of the setting being zero outside mode 0, and a zero setting for a zero step.

Other behaviours only the bench scenarios can show. These are the exact truncated setting values for each element count, the clamping of oversized step indices and the saturation of the setting width. The bench also shows that a pin reset in the middle of the window restarts the full 256 cycles. It computes settings from phase angles in tenths of a degree.

// File: rtl/dllc_pkg.sv
package dllc_pkg;

  typedef enum logic [1:0] {
    FM_LOW  = 2'd0,
    FM_MID  = 2'd1,
    FM_HIGH = 2'd2,
    FM_TOP  = 2'd3
  } freq_mode_e;

  localparam int unsigned NUM_MODES = 4;
  localparam int unsigned SET_W     = 6;
  localparam int unsigned MAX_STEP  = 4;

  // Operating range per mode in MHz, kept for documentation only
  localparam int unsigned FMIN_MHZ [NUM_MODES] = '{100, 150, 200, 240};
  localparam int unsigned FMAX_MHZ [NUM_MODES] = '{175, 230, 310, 400};

  // Delay elements spanning one reference period
  function automatic int unsigned taps_per_period(input int unsigned m);
    case (m)
      0:       return 12;
      1:       return 16;
      2:       return 12;
      default: return 10;
    endcase
  endfunction

  // Largest setting representable in the mode's usable width
  function automatic int unsigned set_limit(input int unsigned m);
    return (m == 0) ? 63 : 31;
  endfunction

  function automatic int unsigned clamp_step(input int unsigned s);
    return (s > MAX_STEP) ? MAX_STEP : s;
  endfunction

  // Truncated phase setting, saturated to the mode's width
  function automatic int unsigned phase_value(input int unsigned code,
                                              input int unsigned step,
                                              input int unsigned m);
    int unsigned q;
    q = (code * step) / taps_per_period(m);
    return (q > set_limit(m)) ? set_limit(m) : q;
  endfunction

endpackage

// File: rtl/dllc_cal_timer.sv
module dllc_cal_timer #(
  parameter int unsigned CAL_CYCLES = 256
) (
  input  logic clk,
  input  logic clr,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CAL_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)
      cnt_q <= '0;
    else if (cnt_q != CNT_END)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_END);
endmodule

// File: rtl/dllc_period_track.sv
module dllc_period_track #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned RST_CODE = 64
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              pd_up,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] CODE_INI = CODE_W'(RST_CODE);

  logic [CODE_W-1:0] code_q;
  logic              can_rise;
  logic              can_fall;

  assign can_rise = (code_q != CODE_MAX);
  assign can_fall = (code_q != CODE_MIN);

  always_ff @(posedge clk) begin
    if (clr)
      code_q <= CODE_INI;
    else if (pd_up && can_rise)
      code_q <= code_q + 1'b1;
    else if (!pd_up && can_fall)
      code_q <= code_q - 1'b1;
  end

  assign code_o = code_q;
endmodule

// File: rtl/dllc_phase_map.sv
module dllc_phase_map
  import dllc_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [SET_W-1:0]  set_o
);
  logic [SEL_W-1:0] step_eff;
  logic [SET_W-1:0] cand [NUM_MODES];

  assign step_eff = SEL_W'(clamp_step(32'(sel_i)));

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    assign cand[m] = SET_W'(phase_value(32'(code_i), 32'(step_eff), m));
  end

  assign set_o = cand[mode_i];
endmodule

// File: rtl/dll_phase_ctrl.sv
module dll_phase_ctrl
  import dllc_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned RST_CODE   = 64,
  parameter int unsigned CAL_CYCLES = 256
) (
  input  logic              clk_ref,
  input  logic              rst_logic,
  input  logic              rst_pin,
  input  logic [1:0]        freq_mode,
  input  logic [SEL_W-1:0]  phase_sel,
  input  logic              pd_up,
  output logic [CODE_W-1:0] period_code,
  output logic [SET_W-1:0]  phase_set,
  output logic              locked
);
  logic              rst_any;
  logic              cal_done;
  logic [CODE_W-1:0] code_w;

  assign rst_any = rst_logic | rst_pin;

  dllc_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk    (clk_ref),
    .clr    (rst_any),
    .done_o (cal_done)
  );

  dllc_period_track #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_track (
    .clk    (clk_ref),
    .clr    (rst_any),
    .pd_up  (pd_up),
    .code_o (code_w)
  );

  dllc_phase_map #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_map (
    .code_i (code_w),
    .mode_i (freq_mode),
    .sel_i  (phase_sel),
    .set_o  (phase_set)
  );

  assign period_code = code_w;
  assign locked      = cal_done;
endmodule

// File: rtl/dllc_checks.sv
module dllc_checks #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned RST_CODE   = 64,
  parameter int unsigned CAL_CYCLES = 256
) (
  input logic              clk,
  input logic              rst_any,
  input logic              pd_up,
  input logic [1:0]        mode,
  input logic [SEL_W-1:0]  sel,
  input logic [CODE_W-1:0] code,
  input logic [5:0]        set,
  input logic              locked
);
  localparam int unsigned CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CODE_W-1:0] CMAX = '1;

  logic          seen_rst = 1'b0;
  logic          prev_rst = 1'b0;
  logic          prev_live = 1'b0;
  logic [CW-1:0] win_cnt = '0;

  always_ff @(posedge clk) begin
    prev_rst  <= rst_any;
    prev_live <= seen_rst && !rst_any;
    if (rst_any) seen_rst <= 1'b1;
    if (rst_any) win_cnt <= '0;
    else if (win_cnt != CW'(CAL_CYCLES)) win_cnt <= win_cnt + 1'b1;
  end

  // R1
  reset_reload_chk: assert property (@(posedge clk)
    prev_rst |-> (code == CODE_W'(RST_CODE) && !locked));

  // R2
  lock_timing_chk: assert property (@(posedge clk) disable iff (rst_any)
    seen_rst && !prev_rst |-> (locked == (win_cnt == CW'(CAL_CYCLES))));

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst_any)
    prev_live && $past(locked) |-> locked);

  // R4
  code_rise_chk: assert property (@(posedge clk) disable iff (rst_any)
    prev_live && $past(pd_up) && $past(code) != CMAX |-> code == $past(code) + 1'b1);

  // R4
  code_fall_chk: assert property (@(posedge clk) disable iff (rst_any)
    prev_live && !$past(pd_up) && $past(code) != '0 |-> code == $past(code) - 1'b1);

  // R5
  code_sat_chk: assert property (@(posedge clk) disable iff (rst_any)
    prev_live && ($past(code) == CMAX && $past(pd_up) || $past(code) == '0 && !$past(pd_up))
      |-> $stable(code));

  // R8
  narrow_width_chk: assert property (@(posedge clk) disable iff (rst_any)
    seen_rst && mode != 2'd0 |-> !set[5]);

  // R7
  zero_step_chk: assert property (@(posedge clk) disable iff (rst_any)
    seen_rst && sel == '0 |-> set == '0);
endmodule

bind dll_phase_ctrl dllc_checks #(
  .CODE_W(CODE_W), .SEL_W(SEL_W), .RST_CODE(RST_CODE), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk     (clk_ref),
  .rst_any (rst_any),
  .pd_up   (pd_up),
  .mode    (freq_mode),
  .sel     (phase_sel),
  .code    (period_code),
  .set     (phase_set),
  .locked  (locked)
);

// File: tb/dll_phase_ctrl_bench.sv
module dll_phase_ctrl_bench;
  logic       clk_ref = 1'b0;
  logic       rst_logic = 1'b1;
  logic       rst_pin = 1'b0;
  logic [1:0] freq_mode = 2'd0;
  logic [2:0] phase_sel = 3'd0;
  logic       pd_up = 1'b0;
  logic [7:0] period_code;
  logic [5:0] phase_set;
  logic       locked;

  always #2 clk_ref = ~clk_ref;

  dll_phase_ctrl u_dll_phase_ctrl (
    .clk_ref(clk_ref), .rst_logic(rst_logic), .rst_pin(rst_pin),
    .freq_mode(freq_mode), .phase_sel(phase_sel), .pd_up(pd_up),
    .period_code(period_code), .phase_set(phase_set), .locked(locked)
  );

  typedef struct {
    int    code;
    int    set;
    bit    lck;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   m_code = 64;
  int   m_cnt = 0;
  bit   done = 0;

  // Setting from the phase angle in tenths of a degree
  function automatic int ref_set(int code, int mode, int sel);
    int step, deg10, v, lim;
    step  = (sel > 4) ? 4 : sel;
    deg10 = (mode == 1) ? 225 : (mode == 3) ? 360 : 300;
    v     = (code * step * deg10) / 3600;
    lim   = (mode == 0) ? 63 : 31;
    return (v > lim) ? lim : v;
  endfunction

  task automatic drive(bit rl, bit rp, bit up, int mode, int sel, string req);
    exp_t e;
    @(negedge clk_ref);
    rst_logic = rl; rst_pin = rp; pd_up = up;
    freq_mode = 2'(mode); phase_sel = 3'(sel);
    if (rl || rp) begin
      m_code = 64; m_cnt = 0;
    end else begin
      if (up && m_code < 255) m_code++;
      else if (!up && m_code > 0) m_code--;
      if (m_cnt < 256) m_cnt++;
    end
    e.code = m_code;
    e.set  = ref_set(m_code, mode, sel);
    e.lck  = (m_cnt == 256);
    e.req  = req;
    q.push_back(e);
  endtask

  always @(posedge clk_ref) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (int'(period_code) != e.code) begin
        n_fail++;
        $display("FAIL %s period_code got %0d exp %0d", e.req, period_code, e.code);
      end
      n_chk++;
      if (int'(phase_set) != e.set) begin
        n_fail++;
        $display("FAIL %s phase_set got %0d exp %0d", e.req, phase_set, e.set);
      end
      n_chk++;
      if (locked != e.lck) begin
        n_fail++;
        $display("FAIL %s locked got %0d exp %0d", e.req, locked, e.lck);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 logic reset
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 0, 1, "R1");
    // R6 R9 window with mixed stimulus across modes and selections
    for (int i = 0; i < 255; i++) drive(0, 0, (i % 3) != 0, i % 4, i % 5, "R6");
    drive(0, 0, 1, 0, 2, "R2");
    // R3 sticky lock
    for (int i = 0; i < 40; i++) drive(0, 0, i[0], (i / 2) % 4, 7 - (i % 8), "R3");
    // R1 pin reset drops lock
    drive(0, 1, 0, 1, 4, "R1");
    // R4 R5 climb to top
    for (int i = 0; i < 200; i++) drive(0, 0, 1, 1, 4, "R5");
    // R8 width saturation
    drive(0, 0, 1, 1, 4, "R8");
    drive(0, 0, 1, 0, 4, "R8");
    drive(0, 0, 1, 3, 4, "R8");
    // R7 clamp and zero step
    drive(0, 0, 1, 2, 7, "R7");
    drive(0, 0, 1, 2, 5, "R7");
    drive(0, 0, 1, 2, 0, "R7");
    // R4 R5 descend to bottom, lock rises on the way
    for (int i = 0; i < 300; i++) drive(0, 0, 0, 3, 3, "R5");
    // R4 recovery from zero
    for (int i = 0; i < 20; i++) drive(0, 0, 1, 2, 2, "R4");
    // R9 mode changing every cycle
    for (int i = 0; i < 16; i++) drive(0, 0, i[1], i % 4, (i % 4) + 1, "R9");
    // R2 restart mid-window
    drive(1, 0, 1, 0, 1, "R1");
    for (int i = 0; i < 100; i++) drive(0, 0, 1, 0, 3, "R2");
    drive(0, 1, 1, 0, 3, "R1");
    for (int i = 0; i < 255; i++) drive(0, 0, i[0], 1, 2, "R2");
    drive(0, 0, 1, 1, 2, "R2");
    drive(0, 0, 0, 1, 2, "R3");
    @(negedge clk_ref);
    @(negedge clk_ref);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule